// File: doc/BRIEF.md
# Dual-Pipe In-Order Write Commit Unit

This block sits behind a two-pipe issue stage. Each cycle it can accept one instruction into pipe X and one into pipe Y. It gives each accepted instruction a wrapping sequence tag and keeps it in a small ordered buffer. The execution pipes report completion by tag, with result data and a fault flag, in any order and after any latency. The block then releases register writes and fault reports strictly in the order the instructions were issued. When both pipes issue in one cycle, the instruction in X counts as the older one.

Issue works as a valid/ready stream per pipe, and the ready lines act as the stall signal. An instruction is accepted on a cycle where its valid and ready are both high. A pipe whose ready is low must hold its instruction. Ready for Y can depend on X's valid, so Y never overtakes X. The ready lines fall for three reasons: a source register names the destination of any instruction still held in the buffer; the buffer lacks room; or a fault is being reported in that cycle.

Completion inputs and the commit outputs are plain strobes with no back-pressure. The register file takes every write it is given. The fault strobe also tells both pipes to drop all work they still hold. The buffer depth must be a power of two, and the tag must be at least one bit wider than the buffer index.

Top module: `dual_pipe_commit`

## Requirements
- R1: After a synchronous reset both ready lines are high, no write or fault strobe is asserted, and the next issued tag is 0.
- R2: An accepted X instruction gets the current tag. Y gets the current tag plus one when X is valid in the same cycle, and the current tag otherwise. Tags wrap modulo 2^TAG_W.
- R3: A pipe's ready is low while either of its sources equals the destination of any instruction still held in the buffer, completed or not. Y's ready is also low when a Y source equals the destination of the valid X instruction in the same cycle.
- R4: At most DEPTH instructions are held at once. X's ready is low when the buffer is full. While X is valid, Y's ready is low unless X is also accepted and two slots are free.
- R5: A completion is matched to a buffered instruction by its full tag, on either pipe, in any order, and both pipes may complete in the same cycle. A completion whose tag matches no buffered instruction has no effect.
- R6: The oldest instruction commits in the cycle after its completion is registered. No instruction commits before all older ones, even when it finished first.
- R7: Up to two instructions commit per cycle. Port 0 carries the oldest. Port 1 carries the next one only if port 0 commits in the same cycle without a fault.
- R8: A committing instruction with its fault flag set raises the fault strobe with its tag, and its own write is suppressed. All younger buffered instructions are discarded, and later completions for them are ignored. An older instruction committing on port 0 in the same cycle still writes.
- R9: Both ready lines are low in the fault cycle. In the next cycle the buffer is empty, and tags continue from the allocation counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| x_in_valid | input | 1 | Instruction offered to pipe X |
| x_in_ready | output | 1 | Pipe X instruction accepted this cycle if valid |
| x_in_dst | input | REG_AW | X destination register |
| x_in_src_a | input | REG_AW | X first source register |
| x_in_src_b | input | REG_AW | X second source register |
| x_in_tag | output | TAG_W | Tag given to the X instruction |
| y_in_valid | input | 1 | Instruction offered to pipe Y |
| y_in_ready | output | 1 | Pipe Y instruction accepted this cycle if valid |
| y_in_dst | input | REG_AW | Y destination register |
| y_in_src_a | input | REG_AW | Y first source register |
| y_in_src_b | input | REG_AW | Y second source register |
| y_in_tag | output | TAG_W | Tag given to the Y instruction |
| x_done_valid | input | 1 | Pipe X completion strobe |
| x_done_tag | input | TAG_W | Tag of the completing X instruction |
| x_done_data | input | DATA_W | X result |
| x_done_exc | input | 1 | X instruction faulted |
| y_done_valid | input | 1 | Pipe Y completion strobe |
| y_done_tag | input | TAG_W | Tag of the completing Y instruction |
| y_done_data | input | DATA_W | Y result |
| y_done_exc | input | 1 | Y instruction faulted |
| wr0_valid | output | 1 | Oldest committed write |
| wr0_addr | output | REG_AW | Register for write 0 |
| wr0_data | output | DATA_W | Data for write 0 |
| wr1_valid | output | 1 | Second committed write |
| wr1_addr | output | REG_AW | Register for write 1 |
| wr1_data | output | DATA_W | Data for write 1 |
| exc_valid | output | 1 | Fault report and pipe discard order |
| exc_tag | output | TAG_W | Tag of the faulting instruction |

## Verification
The assertions check on every cycle that occupancy never goes past the depth and that Y is never taken while an older X waits. They also check that port 1 never writes without port 0, that issue is closed during a fault, that a fault leaves the buffer empty, and that reset empties it. Other behaviours appear only in the bench's scenarios: exact tag values across the wrap, the interlock release timing, the commit order for each completion ordering, and the discarding of stale or flushed completions.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  localparam int DPC_REG_AW = 5;
  localparam int DPC_DATA_W = 32;
  localparam int DPC_DEPTH  = 4;
  localparam int DPC_TAG_W  = 3;

  // number of asserted strobes among two
  function automatic logic [1:0] pair_sum(input logic a, input logic b);
    return {1'b0, a} + {1'b0, b};
  endfunction
endpackage

// File: rtl/dpc_raw_check.sv
module dpc_raw_check #(
  parameter int DEPTH  = 4,
  parameter int REG_AW = 5
) (
  input  logic [DEPTH-1:0]             ent_live,
  input  logic [DEPTH-1:0][REG_AW-1:0] ent_dst,
  input  logic [REG_AW-1:0]            src_a,
  input  logic [REG_AW-1:0]            src_b,
  output logic                         hit
);
  logic [DEPTH-1:0] slot_hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign slot_hit[g] = ent_live[g] && ((ent_dst[g] == src_a) || (ent_dst[g] == src_b));
  end

  assign hit = |slot_hit;
endmodule

// File: rtl/dpc_commit_pick.sv
module dpc_commit_pick (
  input  logic h_vld,
  input  logic h_done,
  input  logic h_exc,
  input  logic n_vld,
  input  logic n_done,
  input  logic n_exc,
  output logic take0,
  output logic take1,
  output logic fault0,
  output logic fault1
);
  always_comb begin
    take0  = h_vld && h_done;
    fault0 = take0 && h_exc;
    take1  = take0 && !h_exc && n_vld && n_done;
    fault1 = take1 && n_exc;
  end
endmodule

// File: rtl/dual_pipe_commit.sv
module dual_pipe_commit #(
  parameter int REG_AW = dpc_pkg::DPC_REG_AW,
  parameter int DATA_W = dpc_pkg::DPC_DATA_W,
  parameter int DEPTH  = dpc_pkg::DPC_DEPTH,
  parameter int TAG_W  = dpc_pkg::DPC_TAG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              x_in_valid,
  output logic              x_in_ready,
  input  logic [REG_AW-1:0] x_in_dst,
  input  logic [REG_AW-1:0] x_in_src_a,
  input  logic [REG_AW-1:0] x_in_src_b,
  output logic [TAG_W-1:0]  x_in_tag,
  input  logic              y_in_valid,
  output logic              y_in_ready,
  input  logic [REG_AW-1:0] y_in_dst,
  input  logic [REG_AW-1:0] y_in_src_a,
  input  logic [REG_AW-1:0] y_in_src_b,
  output logic [TAG_W-1:0]  y_in_tag,
  input  logic              x_done_valid,
  input  logic [TAG_W-1:0]  x_done_tag,
  input  logic [DATA_W-1:0] x_done_data,
  input  logic              x_done_exc,
  input  logic              y_done_valid,
  input  logic [TAG_W-1:0]  y_done_tag,
  input  logic [DATA_W-1:0] y_done_data,
  input  logic              y_done_exc,
  output logic              wr0_valid,
  output logic [REG_AW-1:0] wr0_addr,
  output logic [DATA_W-1:0] wr0_data,
  output logic              wr1_valid,
  output logic [REG_AW-1:0] wr1_addr,
  output logic [DATA_W-1:0] wr1_data,
  output logic              exc_valid,
  output logic [TAG_W-1:0]  exc_tag
);
  localparam int IDX_W = $clog2(DEPTH);

  // ordered buffer, slot index = low tag bits
  logic [DEPTH-1:0]             ent_vld, ent_done, ent_exc;
  logic [DEPTH-1:0][REG_AW-1:0] ent_dst;
  logic [DEPTH-1:0][DATA_W-1:0] ent_data;
  logic [DEPTH-1:0][TAG_W-1:0]  ent_tag;

  logic [TAG_W-1:0] head_tag, alloc_tag, occ;
  logic [IDX_W-1:0] h_idx, n_idx, x_slot, y_slot;
  logic             room1, room2;
  logic             haz_x, haz_y, pair_raw;
  logic             x_fire, y_fire;
  logic             take0, take1, fault0, fault1;

  assign occ    = alloc_tag - head_tag;
  assign room1  = int'(occ) < DEPTH;
  assign room2  = int'(occ) <= DEPTH - 2;
  assign h_idx  = head_tag[IDX_W-1:0];
  assign n_idx  = h_idx + IDX_W'(1);

  // issue side: interlock against everything still buffered
  dpc_raw_check #(.DEPTH(DEPTH), .REG_AW(REG_AW)) u_raw_x (
    .ent_live (ent_vld),
    .ent_dst  (ent_dst),
    .src_a    (x_in_src_a),
    .src_b    (x_in_src_b),
    .hit      (haz_x)
  );

  dpc_raw_check #(.DEPTH(DEPTH), .REG_AW(REG_AW)) u_raw_y (
    .ent_live (ent_vld),
    .ent_dst  (ent_dst),
    .src_a    (y_in_src_a),
    .src_b    (y_in_src_b),
    .hit      (haz_y)
  );

  assign pair_raw = x_in_valid && ((y_in_src_a == x_in_dst) || (y_in_src_b == x_in_dst));

  always_comb begin
    x_in_ready = !exc_valid && !haz_x && room1;
    if (x_in_valid)
      y_in_ready = !exc_valid && !haz_y && x_in_ready && room2 && !pair_raw;
    else
      y_in_ready = !exc_valid && !haz_y && room1;
  end

  assign x_fire   = x_in_valid && x_in_ready;
  assign y_fire   = y_in_valid && y_in_ready;
  assign x_in_tag = alloc_tag;
  assign y_in_tag = alloc_tag + TAG_W'(x_in_valid);
  assign x_slot   = x_in_tag[IDX_W-1:0];
  assign y_slot   = y_in_tag[IDX_W-1:0];

  // commit side: oldest two entries
  dpc_commit_pick u_pick (
    .h_vld  (ent_vld[h_idx]),
    .h_done (ent_done[h_idx]),
    .h_exc  (ent_exc[h_idx]),
    .n_vld  (ent_vld[n_idx]),
    .n_done (ent_done[n_idx]),
    .n_exc  (ent_exc[n_idx]),
    .take0  (take0),
    .take1  (take1),
    .fault0 (fault0),
    .fault1 (fault1)
  );

  assign wr0_valid = take0 && !fault0;
  assign wr0_addr  = ent_dst[h_idx];
  assign wr0_data  = ent_data[h_idx];
  assign wr1_valid = take1 && !fault1;
  assign wr1_addr  = ent_dst[n_idx];
  assign wr1_data  = ent_data[n_idx];
  assign exc_valid = fault0 || fault1;
  assign exc_tag   = fault0 ? ent_tag[h_idx] : ent_tag[n_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_vld   <= '0;
      ent_done  <= '0;
      ent_exc   <= '0;
      head_tag  <= '0;
      alloc_tag <= '0;
    end else if (exc_valid) begin
      // discard every younger entry; nothing issues this cycle
      ent_vld  <= '0;
      ent_done <= '0;
      ent_exc  <= '0;
      head_tag <= alloc_tag;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (x_done_valid && x_done_tag[IDX_W-1:0] == IDX_W'(i) && ent_vld[i] &&
            !ent_done[i] && ent_tag[i] == x_done_tag) begin
          ent_done[i] <= 1'b1;
          ent_data[i] <= x_done_data;
          ent_exc[i]  <= x_done_exc;
        end
        if (y_done_valid && y_done_tag[IDX_W-1:0] == IDX_W'(i) && ent_vld[i] &&
            !ent_done[i] && ent_tag[i] == y_done_tag) begin
          ent_done[i] <= 1'b1;
          ent_data[i] <= y_done_data;
          ent_exc[i]  <= y_done_exc;
        end
      end
      if (take0) begin
        ent_vld[h_idx]  <= 1'b0;
        ent_done[h_idx] <= 1'b0;
      end
      if (take1) begin
        ent_vld[n_idx]  <= 1'b0;
        ent_done[n_idx] <= 1'b0;
      end
      if (x_fire) begin
        ent_vld[x_slot]  <= 1'b1;
        ent_done[x_slot] <= 1'b0;
        ent_exc[x_slot]  <= 1'b0;
        ent_dst[x_slot]  <= x_in_dst;
        ent_tag[x_slot]  <= x_in_tag;
      end
      if (y_fire) begin
        ent_vld[y_slot]  <= 1'b1;
        ent_done[y_slot] <= 1'b0;
        ent_exc[y_slot]  <= 1'b0;
        ent_dst[y_slot]  <= y_in_dst;
        ent_tag[y_slot]  <= y_in_tag;
      end
      head_tag  <= head_tag + TAG_W'(dpc_pkg::pair_sum(take0, take1));
      alloc_tag <= alloc_tag + TAG_W'(dpc_pkg::pair_sum(x_fire, y_fire));
    end
  end

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    int'(occ) <= DEPTH);

  a_r2_y_behind_x: assert property (@(posedge clk) disable iff (rst)
    (x_in_valid && y_in_valid && y_in_ready) |-> x_in_ready);

  a_r7_port1_needs_port0: assert property (@(posedge clk) disable iff (rst)
    wr1_valid |-> wr0_valid);

  a_r9_closed_on_fault: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> (!x_in_ready && !y_in_ready));

  a_r8_fault_empties: assert property (@(posedge clk) disable iff (rst)
    exc_valid |=> (occ == '0 && !wr0_valid && !exc_valid));

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (occ == '0 && !wr0_valid && !exc_valid));
endmodule

// File: tb/dual_pipe_commit_test.sv
module dual_pipe_commit_test;
  localparam int REG_AW = 5;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 4;
  localparam int TAG_W  = 3;
  localparam int TMASK  = (1 << TAG_W) - 1;
  localparam int NVEC   = 6;
  // {mode[1:0], x dst[4:0], y dst[4:0]}; mode 0: X first, 1: Y first, 2: same cycle
  localparam logic [11:0] VEC [NVEC] = '{
    {2'd0, 5'd1,  5'd2},
    {2'd1, 5'd3,  5'd4},
    {2'd2, 5'd5,  5'd6},
    {2'd1, 5'd7,  5'd8},
    {2'd0, 5'd9,  5'd10},
    {2'd2, 5'd11, 5'd12}
  };

  logic clk = 1'b0;
  logic rst;
  logic x_in_valid, x_in_ready, y_in_valid, y_in_ready;
  logic [REG_AW-1:0] x_in_dst, x_in_src_a, x_in_src_b, y_in_dst, y_in_src_a, y_in_src_b;
  logic [TAG_W-1:0] x_in_tag, y_in_tag, x_done_tag, y_done_tag, exc_tag;
  logic x_done_valid, x_done_exc, y_done_valid, y_done_exc;
  logic [DATA_W-1:0] x_done_data, y_done_data, wr0_data, wr1_data;
  logic wr0_valid, wr1_valid, exc_valid;
  logic [REG_AW-1:0] wr0_addr, wr1_addr;

  int checks = 0;
  int errors = 0;
  int exp_tag = 0;
  int t0;

  always #10 clk = ~clk;

  dual_pipe_commit #(.REG_AW(REG_AW), .DATA_W(DATA_W), .DEPTH(DEPTH), .TAG_W(TAG_W)) uut (
    .clk(clk), .rst(rst),
    .x_in_valid(x_in_valid), .x_in_ready(x_in_ready), .x_in_dst(x_in_dst),
    .x_in_src_a(x_in_src_a), .x_in_src_b(x_in_src_b), .x_in_tag(x_in_tag),
    .y_in_valid(y_in_valid), .y_in_ready(y_in_ready), .y_in_dst(y_in_dst),
    .y_in_src_a(y_in_src_a), .y_in_src_b(y_in_src_b), .y_in_tag(y_in_tag),
    .x_done_valid(x_done_valid), .x_done_tag(x_done_tag), .x_done_data(x_done_data),
    .x_done_exc(x_done_exc),
    .y_done_valid(y_done_valid), .y_done_tag(y_done_tag), .y_done_data(y_done_data),
    .y_done_exc(y_done_exc),
    .wr0_valid(wr0_valid), .wr0_addr(wr0_addr), .wr0_data(wr0_data),
    .wr1_valid(wr1_valid), .wr1_addr(wr1_addr), .wr1_data(wr1_data),
    .exc_valid(exc_valid), .exc_tag(exc_tag)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    x_in_valid = 0; y_in_valid = 0;
    x_in_dst = 0; y_in_dst = 0;
    x_in_src_a = 31; x_in_src_b = 31; y_in_src_a = 31; y_in_src_b = 31;
    x_done_valid = 0; y_done_valid = 0; x_done_exc = 0; y_done_exc = 0;
    x_done_tag = 0; y_done_tag = 0; x_done_data = 0; y_done_data = 0;
  endtask

  task automatic issue_x(input int dst);
    x_in_valid = 1; x_in_dst = REG_AW'(dst);
  endtask

  task automatic issue_y(input int dst);
    y_in_valid = 1; y_in_dst = REG_AW'(dst);
  endtask

  task automatic done_x(input int tag, input int data, input bit exc);
    x_done_valid = 1; x_done_tag = TAG_W'(tag); x_done_data = DATA_W'(data); x_done_exc = exc;
  endtask

  task automatic done_y(input int tag, input int data, input bit exc);
    y_done_valid = 1; y_done_tag = TAG_W'(tag); y_done_data = DATA_W'(data); y_done_exc = exc;
  endtask

  task automatic chk_wr0(input string req, input int addr, input int data);
    check(req, int'(wr0_valid), 1);
    check(req, int'(wr0_addr), addr);
    check(req, int'(wr0_data), data);
  endtask

  task automatic chk_wr1(input string req, input int addr, input int data);
    check(req, int'(wr1_valid), 1);
    check(req, int'(wr1_addr), addr);
    check(req, int'(wr1_data), data);
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    clr();
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    #1;
    // R1 reset state
    check("R1 x ready", int'(x_in_ready), 1);
    check("R1 y ready", int'(y_in_ready), 1);
    check("R1 wr0", int'(wr0_valid), 0);
    check("R1 exc", int'(exc_valid), 0);
    check("R1 tag", int'(x_in_tag), 0);

    // vector walk: R2 tags, R5 completion order, R6/R7 ordered commit
    for (int i = 0; i < NVEC; i++) begin
      int mode, xd, yd, xt, yt, xdat, ydat;
      mode = int'(VEC[i][11:10]); xd = int'(VEC[i][9:5]); yd = int'(VEC[i][4:0]);
      xt = exp_tag; yt = (exp_tag + 1) & TMASK;
      xdat = 32'hA000 + i; ydat = 32'hB000 + i;
      @(negedge clk); clr(); issue_x(xd); issue_y(yd); #1;
      check("R2 pair ready x", int'(x_in_ready), 1);
      check("R2 pair ready y", int'(y_in_ready), 1);
      check("R2 x tag", int'(x_in_tag), xt);
      check("R2 y tag", int'(y_in_tag), yt);
      @(negedge clk); clr();
      if (mode != 1) done_x(xt, xdat, 0);
      if (mode != 0) done_y(yt, ydat, 0);
      #1; check("R6 no early commit", int'(wr0_valid), 0);
      @(negedge clk); clr(); #1;
      if (mode == 0) begin
        chk_wr0("R6 x first", xd, xdat);
        check("R7 single", int'(wr1_valid), 0);
        done_y(yt, ydat, 0);
      end else if (mode == 1) begin
        check("R6 younger held", int'(wr0_valid), 0);
        done_x(xt, xdat, 0);
      end else begin
        chk_wr0("R7 pair port0", xd, xdat);
        chk_wr1("R7 pair port1", yd, ydat);
      end
      @(negedge clk); clr(); #1;
      if (mode == 0) begin
        chk_wr0("R6 y after x", yd, ydat);
        check("R7 single y", int'(wr1_valid), 0);
      end else if (mode == 1) begin
        chk_wr0("R6 x released", xd, xdat);
        chk_wr1("R6 y released", yd, ydat);
      end else begin
        check("R6 drained", int'(wr0_valid), 0);
      end
      exp_tag = (exp_tag + 2) & TMASK;
    end

    // R3 interlock on a buffered destination
    @(negedge clk); clr(); issue_x(5); #1;
    t0 = exp_tag;
    check("R2 lone x tag", int'(x_in_tag), t0);
    exp_tag = (exp_tag + 1) & TMASK;
    @(negedge clk); clr(); issue_x(20); x_in_src_a = 5; #1;
    check("R3 raw held", int'(x_in_ready), 0);
    y_in_valid = 1; y_in_dst = 21; y_in_src_b = 5; x_in_valid = 0; #1;
    check("R3 raw held y", int'(y_in_ready), 0);
    y_in_valid = 0; x_in_valid = 1;
    done_x(t0, 55, 0);
    @(negedge clk); x_done_valid = 0; #1;
    check("R3 held during commit", int'(x_in_ready), 0);
    chk_wr0("R3 producer commits", 5, 55);
    @(negedge clk); #1;
    check("R3 released", int'(x_in_ready), 1);
    // R3 same-cycle pair dependency: X accepted, Y held
    issue_y(22); y_in_src_b = 20; #1;
    check("R3 pair x", int'(x_in_ready), 1);
    check("R3 pair y held", int'(y_in_ready), 0);
    t0 = exp_tag;
    exp_tag = (exp_tag + 1) & TMASK;
    @(negedge clk); clr(); done_x(t0, 66, 0);
    @(negedge clk); clr(); #1;
    chk_wr0("R3 pair x commit", 20, 66);
    @(negedge clk); #1;

    // R4 capacity: three lone X, then a pair gets only X, then full
    t0 = exp_tag;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); clr(); issue_x(13 + k); #1;
      check("R4 room", int'(x_in_ready), 1);
    end
    @(negedge clk); clr(); issue_x(16); issue_y(17); #1;
    check("R4 one slot x", int'(x_in_ready), 1);
    check("R4 one slot y", int'(y_in_ready), 0);
    @(negedge clk); clr(); issue_x(18); #1;
    check("R4 full", int'(x_in_ready), 0);
    exp_tag = (exp_tag + 4) & TMASK;
    // R5 stale tag ignored, out-of-order completions
    @(negedge clk); clr(); done_x((t0 + 4) & TMASK, 99, 0);
    @(negedge clk); clr(); #1;
    check("R5 stale ignored", int'(wr0_valid), 0);
    done_x((t0 + 3) & TMASK, 303, 0); done_y((t0 + 1) & TMASK, 101, 0);
    @(negedge clk); clr(); #1;
    check("R6 head missing", int'(wr0_valid), 0);
    done_y(t0, 100, 0);
    @(negedge clk); clr(); #1;
    chk_wr0("R6 oldest", 13, 100);
    chk_wr1("R7 second", 14, 101);
    @(negedge clk); #1;
    check("R6 gap holds", int'(wr0_valid), 0);
    done_x((t0 + 2) & TMASK, 102, 0);
    @(negedge clk); clr(); #1;
    chk_wr0("R6 gap filled", 15, 102);
    chk_wr1("R6 tail", 16, 303);

    // R8 fault on the oldest flushes younger entries
    @(negedge clk); clr(); issue_x(1); issue_y(2);
    t0 = exp_tag;
    @(negedge clk); clr(); issue_x(3);
    exp_tag = (exp_tag + 3) & TMASK;
    @(negedge clk); clr();
    done_y((t0 + 1) & TMASK, 201, 0); done_x((t0 + 2) & TMASK, 202, 0);
    @(negedge clk); clr(); done_x(t0, 200, 1); #1;
    check("R8 before fault", int'(exc_valid), 0);
    @(negedge clk); clr(); issue_x(23); #1;
    check("R8 fault strobe", int'(exc_valid), 1);
    check("R8 fault tag", int'(exc_tag), t0);
    check("R8 fault write dropped", int'(wr0_valid), 0);
    check("R7 no second", int'(wr1_valid), 0);
    check("R9 issue closed", int'(x_in_ready), 0);
    @(negedge clk); clr(); issue_x(24); x_in_src_a = 2; done_y((t0 + 1) & TMASK, 201, 0); #1;
    check("R8 younger flushed", int'(wr0_valid), 0);
    check("R9 reopened", int'(x_in_ready), 1);
    check("R9 tag continues", int'(x_in_tag), exp_tag);
    x_in_valid = 0;
    @(negedge clk); clr(); #1;
    check("R8 late completion ignored", int'(wr0_valid), 0);

    // R8 fault on the second of a pair: older write still goes out
    @(negedge clk); clr(); issue_x(4); issue_y(6);
    t0 = exp_tag;
    exp_tag = (exp_tag + 2) & TMASK;
    @(negedge clk); clr(); done_x(t0, 400, 0); done_y((t0 + 1) & TMASK, 600, 1);
    @(negedge clk); clr(); #1;
    chk_wr0("R8 older writes", 4, 400);
    check("R8 second dropped", int'(wr1_valid), 0);
    check("R8 second fault", int'(exc_valid), 1);
    check("R8 second tag", int'(exc_tag), (t0 + 1) & TMASK);
    @(negedge clk); #1;
    check("R9 empty after", int'(exc_valid), 0);
    check("R9 tag after pair fault", int'(x_in_tag), exp_tag);

    // R1 reset mid-stream
    @(negedge clk); clr(); issue_x(9);
    @(negedge clk); clr(); rst = 1;
    @(negedge clk); rst = 0; #1;
    check("R1 reset tag", int'(x_in_tag), 0);
    check("R1 reset ready", int'(x_in_ready), 1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule